// File: doc/BRIEF.md
# Banked Memory Conflict Serializer

This block sits in front of a 32-bank scratchpad. Each bank is 64 bits wide. A request covers all lanes of a thread group at once. Every lane brings a 32-bit word address and an active bit. A single mode bit picks how words spread over the banks:

- **Narrow interleave:** each 32-bit word goes to the next bank.
- **Wide interleave:** each 64-bit word goes to the next bank.

The block finds the lanes that would collide in a bank. It then splits the request into passes that are free of collisions. It offers one grant mask per pass on a valid/ready output until every active lane has been served. The last beat is flagged and carries the total pass count.

One bank row holds 64 bits. Two lanes that touch the same bank therefore collide only when they need different rows. Lanes reading the same 32-bit word, or the two halves of one 64-bit row, share a pass. This covers the broadcast case.

A new request is taken only once the previous one has finished. The mode bit and the addresses are captured when the request is accepted.

Top module: `bank_conflict_serializer`

## Requirements
- R1: `req_ready` is high exactly when no request is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The first grant beat is offered from the next cycle, with `gnt_count` equal to 1.
- R2: With `req_mode` = 0 (narrow interleave), the bank is address bits [4:0] and the row is the address shifted right by 6. Two active lanes in one bank go to separate passes only if their rows differ. Lanes in one bank and one row share a pass.
- R3: With `req_mode` = 1 (wide interleave), the bank is address bits [5:1] and the row is the address shifted right by 6. Consecutive 64-bit words therefore sit in consecutive banks. Lanes reading different 64-bit words of one bank go to separate passes.
- R4: Any number of active lanes carrying the identical address are served in a single pass, in either mode.
- R5: Inactive lanes never appear in a grant mask. They do not keep any other lane out of a pass.
- R6: Each pass grants the lowest-numbered pending lane. It also grants every other pending lane whose row equals the row of the lowest-numbered pending lane in its bank.
- R7: Every active lane is granted in exactly one beat of its request. A request whose lanes all hit one bank in distinct rows takes one pass per lane, up to 32.
- R8: `gnt_count` is the 1-based number of the current pass. `gnt_done` is high on the final beat only, where `gnt_count` is the total number of passes. After the final beat is taken, `gnt_valid` falls and `req_ready` rises.
- R9: While `gnt_valid` is high and `gnt_ready` is low, `gnt_mask` and `gnt_count` hold their values.
- R10: Changes on `req_mode`, `req_active` and `req_addr` while a request is in progress have no effect on its grants.
- R11: A request with no active lane yields a single beat with an empty mask, `gnt_done` high and `gnt_count` 1.
- R12: After reset, `req_ready` is 1 and `gnt_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_mode | input | 1 | 0: 32-bit interleave, 1: 64-bit interleave |
| req_active | input | LANES | Per-lane active bits |
| req_addr | input | LANES*AW | Per-lane 32-bit word address, lane i at bits [i*AW +: AW] |
| gnt_valid | output | 1 | Grant beat offered |
| gnt_ready | input | 1 | Grant beat consumed |
| gnt_mask | output | LANES | Lanes served in this pass |
| gnt_done | output | 1 | This beat is the last pass |
| gnt_count | output | $clog2(LANES+1) | 1-based pass number |

## Verification
The bench builds the block with its defaults: 32 lanes, 32 banks and 12-bit word addresses. With these values every lane can sit in the same bank on its own row, which gives the 32-pass worst case. Addresses can also cross 64-word row boundaries, which separates the shared-row case from the conflicting one in narrow mode. A reference model computes every grant beat from the bank and row rules. Grant back-pressure is drawn at random, so that held beats and the mode changes made while a request is busy are both covered.

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int AW    = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_mode,
  input  logic [LANES-1:0]           req_active,
  input  logic [LANES*AW-1:0]        req_addr,
  output logic                       gnt_valid,
  input  logic                       gnt_ready,
  output logic [LANES-1:0]           gnt_mask,
  output logic                       gnt_done,
  output logic [$clog2(LANES+1)-1:0] gnt_count
);
  localparam int BW = $clog2(BANKS);
  localparam int RW = AW - BW - 1;
  localparam int CW = $clog2(LANES+1);

  logic             busy;
  logic             mode_q;
  logic [LANES-1:0] pend;
  logic [CW-1:0]    cnt;
  logic [AW-1:0]    addr_q [LANES];
  logic [BW-1:0]    bank   [LANES];
  logic [RW-1:0]    row    [LANES];
  logic [LANES-1:0] sel, hit, left;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bank[g] = mode_q ? addr_q[g][BW:1] : addr_q[g][BW-1:0];
    assign row[g]  = addr_q[g][AW-1:BW+1];
  end

  always_comb begin
    sel = '0;
    hit = '0;
    for (int i = 0; i < LANES; i++) begin
      for (int j = 0; j < i; j++) begin
        if (!hit[i] && pend[j] && bank[j] == bank[i]) begin
          hit[i] = 1'b1;
          sel[i] = pend[i] && (row[j] == row[i]);
        end
      end
      if (!hit[i]) sel[i] = pend[i];
    end
  end

  assign left      = pend & ~sel;
  assign req_ready = !busy;
  assign gnt_valid = busy;
  assign gnt_mask  = sel;
  assign gnt_done  = busy && (left == '0);
  assign gnt_count = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mode_q <= 1'b0;
      pend   <= '0;
      cnt    <= '0;
    end else if (!busy && req_valid) begin
      busy   <= 1'b1;
      mode_q <= req_mode;
      pend   <= req_active;
      cnt    <= CW'(1);
    end else if (busy && gnt_ready) begin
      pend <= left;
      if (left == '0) busy <= 1'b0;
      else            cnt  <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!busy && req_valid)
      for (int i = 0; i < LANES; i++) addr_q[i] <= req_addr[i*AW +: AW];
  end
endmodule

// File: rtl/bank_conflict_serializer_chk.sv
module bank_conflict_serializer_chk #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int AW    = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic [LANES-1:0]           req_active,
  input logic                       gnt_valid,
  input logic                       gnt_ready,
  input logic [LANES-1:0]           gnt_mask,
  input logic                       gnt_done,
  input logic [$clog2(LANES+1)-1:0] gnt_count
);
  logic [LANES-1:0] act_q, served;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      served <= '0;
    end else if (req_valid && req_ready) begin
      act_q  <= req_active;
      served <= '0;
    end else if (gnt_valid && gnt_ready) begin
      served <= served | gnt_mask;
    end
  end

  p_first_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> gnt_valid && gnt_count == 1);

  p_inactive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt_mask & ~act_q) == '0);

  p_progress_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !gnt_done |-> gnt_mask != '0);

  p_no_regrant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt_mask & served) == '0);

  p_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && gnt_done |-> (served | gnt_mask) == act_q);

  p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && gnt_ready && !gnt_done |=> gnt_valid && gnt_count == $past(gnt_count) + 1'b1);

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && gnt_ready && gnt_done |=> !gnt_valid && req_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !gnt_ready |=> gnt_valid && $stable(gnt_mask) && $stable(gnt_count));
endmodule

bind bank_conflict_serializer bank_conflict_serializer_chk #(
  .LANES(LANES), .BANKS(BANKS), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_active(req_active), .gnt_valid(gnt_valid), .gnt_ready(gnt_ready),
  .gnt_mask(gnt_mask), .gnt_done(gnt_done), .gnt_count(gnt_count)
);

// File: tb/sim_bank_conflict_serializer.sv
`timescale 1ns/1ps
module sim_bank_conflict_serializer;
  localparam int LANES = 32;
  localparam int BANKS = 32;
  localparam int AW    = 12;
  localparam int CW    = $clog2(LANES+1);

  typedef struct {
    logic [LANES-1:0] m;
    logic             d;
    int               c;
    string            tag;
  } exp_t;

  logic                clk = 0;
  logic                rst_n = 0;
  logic                req_valid = 0;
  logic                req_ready;
  logic                req_mode = 0;
  logic [LANES-1:0]    req_active = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic                gnt_valid;
  logic                gnt_ready = 0;
  logic [LANES-1:0]    gnt_mask;
  logic                gnt_done;
  logic [CW-1:0]       gnt_count;

  int   checks = 0;
  int   fails  = 0;
  bit   finished = 0;
  exp_t sb[$];

  always #10 clk = ~clk;

  bank_conflict_serializer #(.LANES(LANES), .BANKS(BANKS), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_active(req_active), .req_addr(req_addr),
    .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_mask(gnt_mask),
    .gnt_done(gnt_done), .gnt_count(gnt_count)
  );

  function automatic void model(input logic m, input logic [LANES-1:0] act,
                                input logic [LANES*AW-1:0] flat, input string tag);
    logic [LANES-1:0] pend = act;
    logic [LANES-1:0] mask;
    int claim [BANKS];
    int pass = 0;
    exp_t e;
    if (act == '0) begin
      e.m = '0; e.d = 1'b1; e.c = 1; e.tag = tag;
      sb.push_back(e);
      return;
    end
    while (pend != '0) begin
      pass++;
      mask = '0;
      foreach (claim[k]) claim[k] = -1;
      for (int i = 0; i < LANES; i++) begin
        if (pend[i]) begin
          int a, b, r;
          a = int'(flat[i*AW +: AW]);
          b = m ? (a / 2) % BANKS : a % BANKS;
          r = a / (2 * BANKS);
          if (claim[b] < 0) begin claim[b] = r; mask[i] = 1'b1; end
          else if (claim[b] == r) mask[i] = 1'b1;
        end
      end
      pend = pend & ~mask;
      e.m = mask; e.d = (pend == '0); e.c = pass; e.tag = tag;
      sb.push_back(e);
    end
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic m, input logic [LANES-1:0] act,
                      input logic [LANES*AW-1:0] flat, input string tag);
    model(m, act, flat, tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid  = 1'b1;
    req_mode   = m;
    req_active = act;
    req_addr   = flat;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready && gnt_valid, "R1", "busy after accept",
          {req_ready, gnt_valid}, 2'b01);
    check(gnt_count == 1, "R1", "first count", gnt_count, 1);
    req_mode   = ~m;
    req_active = ~act;
    for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = AW'($urandom);
  endtask

  initial begin : monitor
    logic          held = 0;
    logic [LANES-1:0] hm;
    logic [CW-1:0] hc;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (held)
          check(gnt_valid && gnt_mask == hm && gnt_count == hc, "R9", "held beat",
                {gnt_mask, gnt_count}, {hm, hc});
        gnt_ready = ($urandom % 4) != 0;
        if (gnt_valid && gnt_ready) begin
          if (sb.size() == 0) begin
            check(0, "R8", "unexpected beat", gnt_mask, 0);
          end else begin
            e = sb.pop_front();
            check(gnt_mask == e.m, e.tag, "mask", gnt_mask, e.m);
            check(gnt_done == e.d, "R8", "done", gnt_done, e.d);
            check(int'(gnt_count) == e.c, "R8", "count", gnt_count, e.c);
          end
        end
        held = gnt_valid && !gnt_ready;
        hm = gnt_mask;
        hc = gnt_count;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    logic [LANES*AW-1:0] f;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && gnt_valid == 1'b0, "R12", "reset state",
          {req_ready, gnt_valid}, 2'b10);
    rst_n = 1;

    for (int i = 0; i < LANES; i++) f[i*AW +: AW] = AW'(i);
    send(0, '1, f, "R2");
    send(1, '1, f, "R3");
    for (int i = 0; i < LANES; i++) f[i*AW +: AW] = AW'(2*i + 40);
    send(0, '1, f, "R2");
    send(1, '1, f, "R3");
    for (int i = 0; i < LANES; i++) f[i*AW +: AW] = AW'((i % 16) + 32 * (i / 16));
    send(0, '1, f, "R2");
    for (int i = 0; i < LANES; i++) f[i*AW +: AW] = AW'((i % 16) + 64 * (i / 16));
    send(0, '1, f, "R2");
    for (int i = 0; i < LANES; i++) f[i*AW +: AW] = AW'(2 * (i % 16) + 64 * (i / 16));
    send(1, '1, f, "R3");
    for (int i = 0; i < LANES; i++) f[i*AW +: AW] = AW'(777);
    send(0, '1, f, "R4");
    send(1, '1, f, "R4");
    for (int i = 0; i < LANES; i++) f[i*AW +: AW] = AW'(64 * i);
    send(0, 32'h0000_0220, f, "R5");
    send(1, 32'h8000_0001, f, "R5");
    send(0, '1, f, "R7");
    for (int i = 0; i < LANES; i++) f[i*AW +: AW] = AW'(64 * (i % 3) + 5);
    send(0, '1, f, "R6");
    send(1, 32'hF0F0_1234, f, "R10");
    send(0, '0, f, "R11");
    for (int t = 0; t < 30; t++) begin
      for (int i = 0; i < LANES; i++) f[i*AW +: AW] = AW'($urandom % 256);
      send(t[0], LANES'($urandom), f, "R6");
    end

    while (sb.size() != 0 || gnt_valid) @(negedge clk);
    check(req_ready == 1'b1, "R8", "idle at end", req_ready, 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule